// File: doc/BRIEF.md
# Backlight Converter Supervisory Sequencer

This block is the digital supervisor of a boost converter that drives an LED backlight string. Its inputs are comparator results that have already been turned into synchronous single-bit flags:

- supply above lockout
- output overvoltage
- output short
- over-temperature
- feedback reached

It also receives the standby request and the PWM dimming input. From these it decides four things:

- when the gate switching of the power stage may run,
- when the dimming switch is driven,
- when the loop compensation node is discharged,
- when the voltage reference is powered.

The sequencer leaves standby only after the standby input falls while the supply is good, the output is not shorted and dimming is high. It then runs a soft start of fixed length, which ends early if the feedback flag shows that the LED current has reached its set point. After that it stays in regulation.

Shutdown takes one of two paths:

- **Timed drain.** Raising the standby input, overvoltage or over-temperature stops switching at once. The dimming switch is then held on for a timed drain interval so the output capacitor can discharge, and only after that does the block return to standby.
- **Immediate cut.** A short or a supply collapse cuts everything at once and returns to standby with no drain.

Every return to standby needs a fresh high-to-low edge on the standby input before the block restarts. The drain interval is counted in ticks of a parameterised prescaler, so simulation can use short intervals.

Top module: `bl_seq_top`

## Requirements
- R1: While the synchronous active-low reset is applied, and in the first cycle after it, the state code is 0 (standby) and the gate enable and dimming drive are 0.
- R2: In standby, soft start (state code 1, soft-start flag 1) begins one clock edge after a high-to-low transition of the standby input, provided the supply flag is 1 and the short flag is 0 at that edge. A standby input that is already low when reset is released does not start the block.
- R3: Soft start lasts exactly SS_CYCLES clock cycles and then enters regulation (state code 2). If the feedback-reached flag is 1 earlier, regulation begins at the next edge.
- R4: In soft start and regulation, gate enable and dimming drive follow the dimming input. While dimming is low, the compensation discharge output stays 0, so the compensation node is held.
- R5: A standby input of 1 during soft start or regulation drops gate enable in the same cycle and sets dimming drive and compensation discharge to 1. The block then spends exactly DISCH_TICKS*TICK_DIV cycles in the drain state (state code 3) before standby.
- R6: An overvoltage flag or an over-temperature flag during soft start or regulation behaves exactly like R5. Clearing the flag during the drain does not shorten the drain.
- R7: A short flag, or a supply flag of 0, during soft start, regulation or drain drops gate enable and dimming drive in the same cycle. The block is in standby at the next edge, with no drain.
- R8: When a condition from R7 and a condition from R5 or R6 are present in the same cycle, R7 applies.
- R9: After any return to standby, a standby input that stays low does not restart the block; a new high-to-low edge is required. An edge taken while the supply flag is 0 is remembered, and soft start begins at the first edge after the supply flag returns to 1.
- R10: The reference enable equals the inverse of the standby input. While the standby input is 1, the block stays in standby.
- R11: An armed start that waits because dimming is low, or because the short flag is 1, begins one edge after that condition clears, as long as the standby input stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sup_ok | input | 1 | Supply above lockout |
| ovp_flag | input | 1 | Output overvoltage |
| scp_flag | input | 1 | Output short |
| otp_flag | input | 1 | Over-temperature |
| fb_reached | input | 1 | Feedback has crossed the programmed reference |
| stby_in | input | 1 | Standby request, 1 = standby |
| dim_in | input | 1 | PWM dimming input |
| gate_en | output | 1 | Enable for boost gate switching |
| dim_drv | output | 1 | Dimming switch drive |
| comp_dis | output | 1 | Discharge the compensation node |
| ss_active | output | 1 | Soft start in progress |
| ref_en | output | 1 | Reference enable |
| state_code | output | 2 | 0 standby, 1 soft start, 2 regulation, 3 drain |

## Verification
The embedded properties check several rules on every cycle:

- an immediate-cut condition always leads to standby,
- a drain-class condition on its own always leads to the drain state,
- the drain state is entered only from soft start or regulation,
- soft start is entered only with good supply, high dimming and a low standby input,
- a high standby input keeps the block in standby,
- the interval counters stay in range.

The bench scenarios are needed for the properties that depend on history or on exact durations:

- the exact soft-start and drain lengths,
- that a held-low standby input does not restart the block,
- that an edge taken during undervoltage is remembered,
- an exhaustive sweep of the five shutdown inputs in regulation, which confirms the cut-versus-drain priority and the same-cycle gate cut-off.

// File: rtl/bl_seq_pkg.sv
// Shared types for the backlight supervisory sequencer.
// Assumes a 2-bit state code visible at the top ports.
package bl_seq_pkg;
    typedef enum logic [1:0] {
        ST_STBY  = 2'd0,
        ST_SOFT  = 2'd1,
        ST_RUN   = 2'd2,
        ST_DISCH = 2'd3
    } seq_state_t;
endpackage

// File: rtl/bl_seq_cnt.sv
// Interval counter: counts enabled cycles from 0 up to LIMIT-1.
// WRAP=1 returns to 0 after the last value (prescaler use);
// WRAP=0 saturates at the last value.
// Assumes LIMIT >= 1. 'done' is high while the count sits at LIMIT-1.
module bl_seq_cnt #(
    parameter int LIMIT = 4,
    parameter bit WRAP  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    // Terminal value flag.
    assign done = (cnt == LAST);

    generate
        if (WRAP) begin : g_wrap
            // Wrapping count for tick generation.
            always_ff @(posedge clk) begin
                if (!rst_n || clr)   cnt <= '0;
                else if (en && done) cnt <= '0;
                else if (en)         cnt <= cnt + 1'b1;
            end
        end else begin : g_sat
            // Saturating count for interval measurement.
            always_ff @(posedge clk) begin
                if (!rst_n || clr)    cnt <= '0;
                else if (en && !done) cnt <= cnt + 1'b1;
            end
        end
    endgenerate

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R3
endmodule

// File: rtl/bl_seq_fsm.sv
// Sequencing state machine with start arming and output decode.
// Assumes all flags are synchronous to clk. Gate, dimming and
// discharge outputs react combinationally to fault flags, so a cut-off
// takes effect in the same cycle. Interval completion comes from
// external counters.
module bl_seq_fsm
    import bl_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sup_ok,
    input  logic       ovp_flag,
    input  logic       scp_flag,
    input  logic       otp_flag,
    input  logic       fb_reached,
    input  logic       stby_in,
    input  logic       dim_in,
    input  logic       ss_done,
    input  logic       tick,
    input  logic       dis_done,
    output seq_state_t state,
    output logic       gate_en,
    output logic       dim_drv,
    output logic       comp_dis,
    output logic       ss_active,
    output logic       ref_en
);
    seq_state_t nxt;
    logic stby_q, arm, fall, hard, drainf, active;

    assign fall   = stby_q && !stby_in;
    assign hard   = scp_flag || !sup_ok;
    assign drainf = ovp_flag || otp_flag || stby_in;
    assign active = (state == ST_SOFT) || (state == ST_RUN);

    // Remember the previous standby level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) stby_q <= 1'b0;
        else        stby_q <= stby_in;
    end

    // Arm a start on a falling standby edge seen in standby.
    always_ff @(posedge clk) begin
        if (!rst_n)                          arm <= 1'b0;
        else if (state != ST_STBY || stby_in) arm <= 1'b0;
        else if (fall)                       arm <= 1'b1;
    end

    // Next-state selection with cut-off priority over drain.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_STBY: if (!stby_in && (arm || fall) && sup_ok && !scp_flag && dim_in)
                         nxt = ST_SOFT;
            ST_SOFT: if (hard)                       nxt = ST_STBY;
                     else if (drainf)                nxt = ST_DISCH;
                     else if (ss_done || fb_reached) nxt = ST_RUN;
            ST_RUN:  if (hard)                       nxt = ST_STBY;
                     else if (drainf)                nxt = ST_DISCH;
            ST_DISCH: if (hard || (tick && dis_done)) nxt = ST_STBY;
            default: nxt = ST_STBY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_STBY;
        else        state <= nxt;
    end

    // Output decode.
    always_comb begin
        gate_en   = active && dim_in && !hard && !drainf;
        dim_drv   = !hard && (((state == ST_DISCH)) || (active && (drainf || dim_in)));
        comp_dis  = (state == ST_STBY) || (state == ST_DISCH) || (active && (hard || drainf));
        ss_active = (state == ST_SOFT);
        ref_en    = !stby_in;
    end

    AST_HARD_CUTOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_STBY && hard) |=> state == ST_STBY); // R7

    AST_TIMED_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !hard && drainf) |=> state == ST_DISCH); // R5

    AST_DRAIN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DISCH && $past(state) != ST_DISCH) |-> ($past(state) == ST_SOFT || $past(state) == ST_RUN)); // R6

    AST_START_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SOFT && $past(state) == ST_STBY) |-> $past(sup_ok && dim_in && !stby_in && !scp_flag)); // R2

    AST_STBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STBY && stby_in) |=> state == ST_STBY); // R10
endmodule

// File: rtl/bl_seq_top.sv
// Backlight converter supervisory sequencer, top level.
// Instantiates the state machine, the soft-start counter, the drain
// tick prescaler and the drain tick counter. The drain lasts
// DISCH_TICKS*TICK_DIV cycles; soft start lasts SS_CYCLES cycles.
module bl_seq_top
    import bl_seq_pkg::*;
#(
    parameter int SS_CYCLES   = 4096,
    parameter int TICK_DIV    = 125000,
    parameter int DISCH_TICKS = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sup_ok,
    input  logic       ovp_flag,
    input  logic       scp_flag,
    input  logic       otp_flag,
    input  logic       fb_reached,
    input  logic       stby_in,
    input  logic       dim_in,
    output logic       gate_en,
    output logic       dim_drv,
    output logic       comp_dis,
    output logic       ss_active,
    output logic       ref_en,
    output logic [1:0] state_code
);
    seq_state_t state;
    logic ss_done, tick, dis_done;

    // Soft-start interval, cleared outside soft start.
    bl_seq_cnt #(.LIMIT(SS_CYCLES), .WRAP(1'b0)) u_ss_cnt (
        .clk(clk), .rst_n(rst_n), .clr(state != ST_SOFT), .en(1'b1), .done(ss_done));

    // Tick prescaler, restarted on drain entry.
    bl_seq_cnt #(.LIMIT(TICK_DIV), .WRAP(1'b1)) u_tick_pre (
        .clk(clk), .rst_n(rst_n), .clr(state != ST_DISCH), .en(1'b1), .done(tick));

    // Drain length in ticks.
    bl_seq_cnt #(.LIMIT(DISCH_TICKS), .WRAP(1'b0)) u_dis_cnt (
        .clk(clk), .rst_n(rst_n), .clr(state != ST_DISCH), .en(tick), .done(dis_done));

    bl_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sup_ok(sup_ok), .ovp_flag(ovp_flag),
        .scp_flag(scp_flag), .otp_flag(otp_flag), .fb_reached(fb_reached),
        .stby_in(stby_in), .dim_in(dim_in), .ss_done(ss_done), .tick(tick),
        .dis_done(dis_done), .state(state), .gate_en(gate_en), .dim_drv(dim_drv),
        .comp_dis(comp_dis), .ss_active(ss_active), .ref_en(ref_en));

    assign state_code = state;
endmodule

// File: tb/bl_seq_top_tb_top.sv
`timescale 1ns/1ps
module bl_seq_top_tb_top;
    localparam int SS = 10;
    localparam int TD = 3;
    localparam int DT = 4;
    localparam int DN = TD * DT;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sup_ok = 1'b1, ovp = 1'b0, scp = 1'b0, otp = 1'b0, fb = 1'b0, stby = 1'b1, dim = 1'b1;
    logic gate_en, dim_drv, comp_dis, ss_active, ref_en;
    logic [1:0] st;
    int total = 0, bad = 0;
    bit fin = 1'b0;

    always #4 clk = ~clk;

    bl_seq_top #(.SS_CYCLES(SS), .TICK_DIV(TD), .DISCH_TICKS(DT)) dut_i (
        .clk(clk), .rst_n(rst_n), .sup_ok(sup_ok), .ovp_flag(ovp), .scp_flag(scp),
        .otp_flag(otp), .fb_reached(fb), .stby_in(stby), .dim_in(dim),
        .gate_en(gate_en), .dim_drv(dim_drv), .comp_dis(comp_dis),
        .ss_active(ss_active), .ref_en(ref_en), .state_code(st));

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic go_stby();
        stby = 1'b1; ovp = 1'b0; otp = 1'b0; scp = 1'b0; sup_ok = 1'b1; fb = 1'b0; dim = 1'b1;
        for (int i = 0; i < 100 && st != 2'd0; i++) step(1);
        step(1);
    endtask

    task automatic go_run();
        go_stby();
        stby = 1'b0;
        step(1);
        chk("R2 start", st, 1);
        fb = 1'b1;
        step(1);
        chk("R3 fb handoff", st, 2);
        fb = 1'b0;
    endtask

    task automatic count_drain(input string tag);
        int n;
        n = 0;
        while (st == 2'd3 && n < 200) begin n++; step(1); end
        chk(tag, n, DN);
        chk(tag, st, 0);
        chk(tag, dim_drv, 0);
    endtask

    initial begin
        int n;
        // R1: reset state, with standby held low during reset
        stby = 1'b0;
        step(3);
        chk("R1 state", st, 0);
        chk("R1 gate", gate_en, 0);
        chk("R1 dim", dim_drv, 0);
        rst_n = 1'b1;
        step(1);
        chk("R1 post-reset state", st, 0);
        step(3);
        chk("R2 low level no start", st, 0);
        chk("R10 ref on", ref_en, 1);

        // R10: standby high keeps standby
        stby = 1'b1;
        #1 chk("R10 ref off", ref_en, 0);
        step(20);
        chk("R10 held", st, 0);

        // R2 / R3: start and full soft-start length
        stby = 1'b0;
        step(1);
        chk("R2 soft", st, 1);
        chk("R2 ss flag", ss_active, 1);
        n = 0;
        while (st == 2'd1 && n < 100) begin n++; step(1); end
        chk("R3 soft length", n, SS);
        chk("R3 run", st, 2);
        chk("R3 ss flag off", ss_active, 0);

        // R4: dimming in regulation
        chk("R4 gate on", gate_en, 1);
        dim = 1'b0;
        #1;
        chk("R4 gate off", gate_en, 0);
        chk("R4 dim off", dim_drv, 0);
        chk("R4 comp held", comp_dis, 0);
        step(3);
        chk("R4 still run", st, 2);
        dim = 1'b1;
        #1 chk("R4 dim on", dim_drv, 1);

        // R4: dimming in soft start
        go_stby();
        stby = 1'b0;
        step(1);
        dim = 1'b0;
        #1;
        chk("R4 soft gate", gate_en, 0);
        chk("R4 soft comp", comp_dis, 0);
        chk("R4 soft flag", ss_active, 1);
        dim = 1'b1;

        // R11: armed start waits for dimming, then for short clear
        go_stby();
        dim = 1'b0; stby = 1'b0;
        step(3);
        chk("R11 wait dim", st, 0);
        dim = 1'b1;
        step(1);
        chk("R11 start dim", st, 1);
        go_stby();
        scp = 1'b1; stby = 1'b0;
        step(3);
        chk("R11 wait short", st, 0);
        scp = 1'b0;
        step(1);
        chk("R11 start short", st, 1);

        // R5: standby rise drains
        go_run();
        stby = 1'b1;
        #1;
        chk("R5 gate cut", gate_en, 0);
        chk("R5 dim hold", dim_drv, 1);
        chk("R5 comp dis", comp_dis, 1);
        step(1);
        chk("R5 drain", st, 3);
        count_drain("R5 drain len");

        // R6: overvoltage and over-temperature, plus R9 restart rule
        for (int k = 0; k < 2; k++) begin
            go_run();
            if (k == 0) ovp = 1'b1; else otp = 1'b1;
            #1;
            chk("R6 gate cut", gate_en, 0);
            chk("R6 dim hold", dim_drv, 1);
            step(1);
            chk("R6 drain", st, 3);
            ovp = 1'b0; otp = 1'b0;
            count_drain("R6 drain len");
            step(5);
            chk("R9 no restart low", st, 0);
            stby = 1'b1; step(1);
            stby = 1'b0; step(1);
            chk("R9 restart edge", st, 1);
        end

        // R7: short cut
        go_run();
        scp = 1'b1;
        #1;
        chk("R7 short gate", gate_en, 0);
        chk("R7 short dim", dim_drv, 0);
        step(1);
        chk("R7 short stby", st, 0);
        scp = 1'b0;

        // R7 / R9: undervoltage cut and remembered edge
        go_run();
        sup_ok = 1'b0;
        #1;
        chk("R7 uv gate", gate_en, 0);
        chk("R7 uv dim", dim_drv, 0);
        step(1);
        chk("R7 uv stby", st, 0);
        sup_ok = 1'b1;
        step(5);
        chk("R9 uv no restart", st, 0);
        sup_ok = 1'b0;
        stby = 1'b1; step(1);
        stby = 1'b0; step(3);
        chk("R9 uv waits", st, 0);
        sup_ok = 1'b1;
        step(1);
        chk("R9 uv start", st, 1);

        // R8: cut during drain
        go_run();
        stby = 1'b1;
        step(1);
        chk("R8 drain", st, 3);
        scp = 1'b1;
        #1 chk("R8 drain dim cut", dim_drv, 0);
        step(1);
        chk("R8 drain cut", st, 0);

        // R8: exhaustive sweep of shutdown inputs in regulation
        for (int m = 0; m < 32; m++) begin
            bit h, d;
            go_run();
            scp = m[4]; sup_ok = !m[3]; ovp = m[2]; otp = m[1]; stby = m[0];
            h = m[4] | m[3];
            d = m[2] | m[1] | m[0];
            #1;
            chk("R8 sweep gate", gate_en, (!h && !d) ? 1 : 0);
            chk("R8 sweep dim", dim_drv, h ? 0 : 1);
            step(1);
            chk("R8 sweep state", st, h ? 0 : (d ? 3 : 2));
        end

        fin = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!fin) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule